// File: doc/BRIEF.md
# DMA Descriptor Table Fetch Unit

This block locates and reads the control descriptor of one channel of a multi-channel DMA engine whose descriptors live in RAM. Software programs a 32-bit table base address as two 16-bit halves and sets a global enable bit. Channel 0's descriptor starts at the base. Each later channel's descriptor follows at a fixed stride of four 32-bit words (16 bytes).

When the transfer engine raises a request that carries a 7-bit channel number, the unit computes the descriptor start address. It then reads the four words one at a time over a simple read port and hands them back with a one-cycle valid pulse. While the engine is enabled the base address is locked, so a table that is in use cannot move under a running fetch.

The register port decodes a 2-bit address. Address 0 is the low base half and address 1 is the high base half. Address 2 is the control register, whose bit 0 is the enable. Reads of either base half return zero. A read of the control register returns the enable in bit 0.

Top module: `dma_desc_fetch`

## Requirements
- R1: After reset the table base is 0x200003A0 and the enable is 0. `reqReady`, `memRdEn` and `descValid` are all low.
- R2: `reqReady` is high exactly when the enable is 1 and no fetch is in progress. A request that is presented while `reqReady` is low is not taken.
- R3: The first read of a fetch uses the address base + channel × 16, wrapping modulo 2^32.
- R4: A fetch issues exactly four reads at ascending addresses spaced 4 bytes apart. Each `memRdEn` is a single cycle, and no new read is issued until `memRdValid` has returned the previous one.
- R5: Once the fourth word is captured, `descValid` is high for exactly one cycle. In that cycle `descChan` holds the requested channel, and `descWords[32k+31:32k]` holds the word read from start + 4k, for k = 0..3.
- R6: A write to either base half (register address 0 or 1) is ignored while the enable is 1.
- R7: A write to the low base half always stores bits 3:0 as zero, so the base stays 16-byte aligned.
- R8: Clearing the enable in the middle of a fetch lets that fetch complete with its `descValid` pulse. After that, no further request is accepted until the enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 base low, 1 base high, 2 control |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (base halves read zero; control bit 0 is the enable) |
| reqValid | input | 1 | Channel request valid |
| reqChan | input | 7 | Requested channel number |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| memRdEn | output | 1 | One-cycle read command |
| memAddr | output | 32 | Byte address of the read |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Read data |
| descValid | output | 1 | One-cycle descriptor-ready pulse |
| descChan | output | 7 | Channel of the presented descriptor |
| descWords | output | 128 | Four descriptor words, word k at bits 32k+31:32k |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 7-bit channel numbers, four 4-byte words per descriptor and the 0x200003A0 reset base. With these values the test can reach channel 127, where the stride offset is 0x7F0. It can also reach a base near the top of the address space, where the start address wraps. The bench's memory model answers with a latency of one to three cycles. This shows that the fetch waits on `memRdValid` rather than on a fixed count.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } fetch_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // latch channel and start address, clear word index
    logic capture;  // store returned word, advance word index
  } dp_strobe_t;

  localparam int REG_AW = 2;

endpackage

// File: rtl/dma_desc_ctrl.sv
module dma_desc_ctrl
  import dma_desc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dmaEnable,
  input  logic       reqValid,
  input  logic       memRdValid,
  input  logic       lastWord,
  output logic       reqReady,
  output logic       memRdEn,
  output logic       descValid,
  output dp_strobe_t strobe
);

  fetch_state_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD         = stateQ;
    reqReady       = 1'b0;
    memRdEn        = 1'b0;
    descValid      = 1'b0;
    strobe         = '0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = dmaEnable;
        if (reqValid && dmaEnable) begin
          strobe.accept = 1'b1;
          stateD        = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        memRdEn = 1'b1;
        stateD  = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRdValid) begin
          strobe.capture = 1'b1;
          stateD         = lastWord ? ST_DONE : ST_ISSUE;
        end
      end
      ST_DONE: begin
        descValid = 1'b1;
        stateD    = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dma_desc_dpath.sv
module dma_desc_dpath
  import dma_desc_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          HALF_W     = 16,
  parameter int          CH_W       = 7,
  parameter int          WORD_W     = 32,
  parameter int          WORDS      = 4,
  parameter int          WORD_BYTES = 4,
  parameter logic [31:0] RESET_BASE = 32'h2000_03A0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [REG_AW-1:0]       regAddr,
  input  logic [HALF_W-1:0]       regWdata,
  output logic [HALF_W-1:0]       regRdata,
  input  logic [CH_W-1:0]         reqChan,
  input  logic [WORD_W-1:0]       memRdData,
  input  dp_strobe_t              strobe,
  output logic                    dmaEnable,
  output logic [ADDR_W-1:0]       baseAddr,
  output logic                    lastWord,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [CH_W-1:0]         descChan,
  output logic [WORDS*WORD_W-1:0] descWords
);

  localparam int HALVES       = ADDR_W / HALF_W;
  localparam int STRIDE_BYTES = WORDS * WORD_BYTES;
  localparam int STRIDE_SH    = $clog2(STRIDE_BYTES);
  localparam int WORD_SH      = $clog2(WORD_BYTES);
  localparam int IDX_W        = $clog2(WORDS);
  localparam logic [REG_AW-1:0] CTRL_ADDR = REG_AW'(HALVES);

  logic [ADDR_W-1:0] baseQ, baseD;
  logic              enableQ;
  logic [CH_W-1:0]   chanQ;
  logic [ADDR_W-1:0] startQ;
  logic [IDX_W-1:0]  idxQ;
  logic [WORD_W-1:0] wordQ [WORDS];

  // base register: writable half by half only while disabled, always aligned
  always_comb begin
    baseD = baseQ;
    for (int h = 0; h < HALVES; h++) begin
      if (regWe && !enableQ && (regAddr == REG_AW'(h)))
        baseD[h*HALF_W +: HALF_W] = regWdata;
    end
    baseD[STRIDE_SH-1:0] = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ   <= ADDR_W'(RESET_BASE) & ~ADDR_W'(STRIDE_BYTES - 1);
      enableQ <= 1'b0;
    end else begin
      baseQ <= baseD;
      if (regWe && (regAddr == CTRL_ADDR)) enableQ <= regWdata[0];
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == CTRL_ADDR) regRdata[0] = enableQ;
  end

  // channel, descriptor start and word index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanQ  <= '0;
      startQ <= '0;
      idxQ   <= '0;
    end else if (strobe.accept) begin
      chanQ  <= reqChan;
      startQ <= baseQ + (ADDR_W'(reqChan) << STRIDE_SH);
      idxQ   <= '0;
    end else if (strobe.capture) begin
      idxQ   <= idxQ + 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          wordQ[g] <= '0;
        else if (strobe.capture && (idxQ == IDX_W'(g)))
          wordQ[g] <= memRdData;
      end
      assign descWords[g*WORD_W +: WORD_W] = wordQ[g];
    end
  endgenerate

  assign memAddr   = startQ + (ADDR_W'(idxQ) << WORD_SH);
  assign lastWord  = (idxQ == IDX_W'(WORDS - 1));
  assign descChan  = chanQ;
  assign dmaEnable = enableQ;
  assign baseAddr  = baseQ;

endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dma_desc_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          HALF_W     = 16,
  parameter int          CH_W       = 7,
  parameter int          WORD_W     = 32,
  parameter int          WORDS      = 4,
  parameter int          WORD_BYTES = 4,
  parameter logic [31:0] RESET_BASE = 32'h2000_03A0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [1:0]              regAddr,
  input  logic [HALF_W-1:0]       regWdata,
  output logic [HALF_W-1:0]       regRdata,
  input  logic                    reqValid,
  input  logic [CH_W-1:0]         reqChan,
  output logic                    reqReady,
  output logic                    memRdEn,
  output logic [ADDR_W-1:0]       memAddr,
  input  logic                    memRdValid,
  input  logic [WORD_W-1:0]       memRdData,
  output logic                    descValid,
  output logic [CH_W-1:0]         descChan,
  output logic [WORDS*WORD_W-1:0] descWords
);

  dp_strobe_t        strobe;
  logic              dmaEnable;
  logic              lastWord;
  logic [ADDR_W-1:0] baseAddr;

  dma_desc_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dmaEnable  (dmaEnable),
    .reqValid   (reqValid),
    .memRdValid (memRdValid),
    .lastWord   (lastWord),
    .reqReady   (reqReady),
    .memRdEn    (memRdEn),
    .descValid  (descValid),
    .strobe     (strobe)
  );

  dma_desc_dpath #(
    .ADDR_W     (ADDR_W),
    .HALF_W     (HALF_W),
    .CH_W       (CH_W),
    .WORD_W     (WORD_W),
    .WORDS      (WORDS),
    .WORD_BYTES (WORD_BYTES),
    .RESET_BASE (RESET_BASE)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .reqChan   (reqChan),
    .memRdData (memRdData),
    .strobe    (strobe),
    .dmaEnable (dmaEnable),
    .baseAddr  (baseAddr),
    .lastWord  (lastWord),
    .memAddr   (memAddr),
    .descChan  (descChan),
    .descWords (descWords)
  );

endmodule

// File: rtl/dma_desc_fetch_chk.sv
module dma_desc_fetch_chk #(
  parameter int ADDR_W  = 32,
  parameter int ALIGN_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [1:0]        regAddr,
  input logic              reqValid,
  input logic              reqReady,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdValid,
  input logic              descValid,
  input logic              dmaEnable,
  input logic [ADDR_W-1:0] baseAddr
);

  logic pendQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pendQ <= 1'b0;
    else if (memRdEn)    pendQ <= 1'b1;
    else if (memRdValid) pendQ <= 1'b0;
  end

  // R2
  ready_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dmaEnable |-> !reqReady);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R3
  first_read_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (memRdEn && memAddr[ALIGN_W-1:0] == '0));

  // R4
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> !pendQ);

  // R4
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  // R5
  desc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    descValid |=> !descValid);

  // R6
  base_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaEnable && regWe && regAddr != 2'd2) |=> $stable(baseAddr));

endmodule

bind dma_desc_fetch dma_desc_fetch_chk #(.ADDR_W(ADDR_W), .ALIGN_W($clog2(WORDS*WORD_BYTES))) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWe      (regWe),
  .regAddr    (regAddr),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .memRdEn    (memRdEn),
  .memAddr    (memAddr),
  .memRdValid (memRdValid),
  .descValid  (descValid),
  .dmaEnable  (dmaEnable),
  .baseAddr   (baseAddr)
);

// File: tb/test_dma_desc_fetch.sv
module test_dma_desc_fetch;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWe = 1'b0;
  logic [1:0]   regAddr = '0;
  logic [15:0]  regWdata = '0;
  logic [15:0]  regRdata;
  logic         reqValid = 1'b0;
  logic [6:0]   reqChan = '0;
  logic         reqReady;
  logic         memRdEn;
  logic [31:0]  memAddr;
  logic         memRdValid;
  logic [31:0]  memRdData;
  logic         descValid;
  logic [6:0]   descChan;
  logic [127:0] descWords;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dma_desc_fetch i_dma_desc_fetch (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .reqValid(reqValid), .reqChan(reqChan), .reqReady(reqReady),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .descValid(descValid), .descChan(descChan), .descWords(descWords)
  );

  // memory model: fixed latency per test, pattern data from address
  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'hC3C3_3C3C;
  endfunction

  int          memLat = 1;
  int          cnt = 0;
  logic [31:0] addrQ = '0;
  logic [31:0] addrLog [256];
  int          logN = 0;
  int          overlap = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      memRdValid <= 1'b0;
      memRdData  <= '0;
      cnt        <= 0;
    end else begin
      memRdValid <= 1'b0;
      if (cnt > 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin
          memRdValid <= 1'b1;
          memRdData  <= pat(addrQ);
        end
      end
      if (memRdEn) begin
        if (cnt != 0 || memRdValid) overlap <= overlap + 1;
        addrLog[logN & 255] <= memAddr;
        logN  <= logN + 1;
        addrQ <= memAddr;
        cnt   <= memLat;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitDesc(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (descValid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic checkDesc(input logic [6:0] ch, input logic [31:0] exp, input int startLog);
    check(descChan == ch, "R5", "descriptor channel", 32'(descChan), 32'(ch));
    for (int k = 0; k < 4; k++)
      check(descWords[32*k +: 32] == pat(exp + 32'(4*k)), "R5", "descriptor word",
            descWords[32*k +: 32], pat(exp + 32'(4*k)));
    check(logN - startLog == 4, "R4", "read count", 32'(logN - startLog), 32'd4);
    check(addrLog[startLog & 255] == exp, "R3", "first read address",
          addrLog[startLog & 255], exp);
    for (int k = 1; k < 4; k++)
      check(addrLog[(startLog + k) & 255] == exp + 32'(4*k), "R4", "ascending read address",
            addrLog[(startLog + k) & 255], exp + 32'(4*k));
  endtask

  task automatic doFetch(input logic [6:0] ch, input logic [31:0] exp, input int lat);
    int  startLog;
    bit  seen;
    memLat = lat;
    @(negedge clk);
    startLog = logN;
    reqValid = 1'b1; reqChan = ch;
    check(reqReady == 1'b1, "R2", "ready when idle and enabled", 32'(reqReady), 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R2", "ready low while busy", 32'(reqReady), 32'd0);
    waitDesc(seen);
    check(seen, "R5", "descriptor valid seen", 32'(seen), 32'd1);
    checkDesc(ch, exp, startLog);
    @(negedge clk);
    check(descValid == 1'b0, "R5", "valid one cycle only", 32'(descValid), 32'd0);
    check(reqReady == 1'b1, "R2", "ready after fetch", 32'(reqReady), 32'd1);
  endtask

  typedef struct packed {
    logic        wr;
    logic [15:0] lo;
    logic [15:0] hi;
    logic [6:0]  ch;
    logic [3:0]  lat;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 16'h0000, 16'h0000, 7'd0,   4'd1, 32'h2000_03A0},  // R1 reset base, R3
    '{1'b0, 16'h0000, 16'h0000, 7'd127, 4'd2, 32'h2000_0B90},  // R3 top channel
    '{1'b1, 16'h5670, 16'h1234, 7'd5,   4'd1, 32'h1234_56C0},  // R3
    '{1'b1, 16'hFFFF, 16'h0000, 7'd1,   4'd3, 32'h0001_0000},  // R7 low bits dropped
    '{1'b1, 16'hFFF0, 16'hFFFF, 7'd127, 4'd1, 32'h0000_07E0},  // R3 wrap
    '{1'b1, 16'h000F, 16'h8000, 7'd64,  4'd2, 32'h8000_0400}   // R7
  };

  initial begin
    bit seen;
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b0, "R1", "reqReady in reset", 32'(reqReady), 32'd0);
    check(memRdEn == 1'b0, "R1", "memRdEn in reset", 32'(memRdEn), 32'd0);
    check(descValid == 1'b0, "R1", "descValid in reset", 32'(descValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b0, "R1", "disabled after reset", 32'(reqReady), 32'd0);

    // R2: request while disabled is not taken
    base = logN;
    reqValid = 1'b1; reqChan = 7'd9;
    repeat (5) @(negedge clk);
    reqValid = 1'b0;
    check(logN == base, "R2", "no read while disabled", 32'(logN - base), 32'd0);

    foreach (VECS[i]) begin
      if (VECS[i].wr) begin
        regWrite(2'd2, 16'h0000);
        regWrite(2'd0, VECS[i].lo);
        regWrite(2'd1, VECS[i].hi);
      end
      regWrite(2'd2, 16'h0001);
      doFetch(VECS[i].ch, VECS[i].exp, int'(VECS[i].lat));
    end

    // R6: base writes ignored while enabled (base is 0x80000000)
    regWrite(2'd0, 16'h1230);
    regWrite(2'd1, 16'h4444);
    doFetch(7'd2, 32'h8000_0020, 2);

    // R8: clear enable mid-fetch
    memLat = 3;
    @(negedge clk);
    base = logN;
    reqValid = 1'b1; reqChan = 7'd3;
    @(negedge clk);
    reqChan = 7'd11;            // keep requesting another channel
    regWrite(2'd2, 16'h0000);
    waitDesc(seen);
    check(seen, "R8", "fetch completes after disable", 32'(seen), 32'd1);
    checkDesc(7'd3, 32'h8000_0030, base);
    base = logN;
    repeat (10) begin
      @(negedge clk);
      if (descValid || reqReady) seen = 1'b0;
    end
    check(seen, "R8", "no accept after disable", 32'(reqReady), 32'd0);
    check(logN == base, "R8", "no reads after disable", 32'(logN - base), 32'd0);
    reqValid = 1'b0;

    check(overlap == 0, "R4", "overlapping reads", 32'(overlap), 32'd0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule